// File: doc/BRIEF.md
# Reference Clock Pre-Divider Selector

This block sits in front of a phase comparator and turns each of several reference clock inputs into a stream of phase-comparison events. Every reference is first brought into the fast system clock domain. One chosen edge type is then detected and counted. Each time a division period completes, the block raises a one-cycle event pulse. A channel either passes every chosen edge through, divides by a preset ratio that brings a known spot frequency down to 8 kHz, or divides by a programmable factor N+1. All channels in the last mode share that factor.

Each channel has a configuration byte. Bit 7 selects the programmable divide and takes priority over bit 6, which selects the preset divide. With neither bit set, the channel is direct. The low nibble is a spot-frequency code for the preset divide. Bits 5:4 are a tag that the divider does not use. The shared N is written one byte at a time, through a high-byte strobe and a low-byte strobe that share a data bus. A single global input chooses rising or falling edges for every channel. The event outputs are fire-and-forget pulses with no ready signal, so back-pressure is not possible: a consumer must accept every pulse in the cycle it appears.

Top module: `refclk_prediv`

## Requirements
- R1: With bits 7:6 of the configuration byte equal to 00 (direct), a channel emits exactly one event for every selected edge of its reference.
- R2: With bit 7 set (programmable divide), a channel emits one event for every N+1 selected edges, where N is the 16-bit value {high byte, low byte}.
- R3: N is legal from 1 to 12499 inclusive, which gives ratios 2 to 12500. n_err is high exactly while the stored N is 0 or above 12499, and it changes only after a write strobe. While n_err is high, programmable-divide channels emit no events. Writing a legal N restores them.
- R4: With bits 7:6 = 01 (preset divide), the low-nibble code sets the ratio: 1→193, 2→256, 3→810, 4→2430, 5→3240, 6→4860, 7→6480, 8→9720.
- R5: In preset mode, any other code drives that channel's code_err high, and the channel emits no events. code_err is low in the other modes.
- R6: When bits 7 and 6 are both set, the programmable divide is used, and code_err stays low whatever the code.
- R7: Changing bits 5:4 of a configuration byte neither alters the ratio nor restarts the division period.
- R8: edge_fall = 0 counts rising reference edges, and edge_fall = 1 counts falling edges. The other edge type never produces an event.
- R9: A channel's division count restarts on any change of its mode or code bits, on any N write strobe, and on any change of edge_fall. No event appears in the cycle after such a restart.
- R10: Each event is exactly one cycle wide. A selected reference transition applied before clock edge k shows on evt_out just after clock edge k+2.
- R11: After reset, N = 1, n_err = 0, and no events are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than twice any reference |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_clk_in | input | NUM_REFS | Asynchronous reference clocks |
| chan_cfg | input | NUM_REFS*8 | Per-channel configuration bytes, channel 0 in the low byte |
| edge_fall | input | 1 | 0: count rising edges, 1: count falling edges |
| n_hi_we | input | 1 | Write n_wdata into the high byte of N |
| n_lo_we | input | 1 | Write n_wdata into the low byte of N |
| n_wdata | input | 8 | Write data for N |
| evt_out | output | NUM_REFS | One-cycle phase-comparison events |
| n_err | output | 1 | Stored N is outside the legal range |
| code_err | output | NUM_REFS | Preset mode with an unsupported code |

## Verification
The checker watches several rules on every cycle: events are single-cycle pulses, a channel flagged by code_err stays silent, programmable-divide channels stay silent while N is illegal, no event follows an N write, and n_err moves only after a write. The ratio values, the preset table, edge polarity, the fixed three-cycle latency and the restart on mode or polarity changes depend on counting many reference edges against configured values. Only the bench's scenarios, which drive known edge counts and compare event totals and timing, can show those.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  localparam int RATIO_W = 14;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_AUTO8K = 2'd1,
    MODE_DIVN   = 2'd2
  } mode_e;

  // sel = {programmable-divide bit, preset-divide bit}; programmable wins
  function automatic mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return MODE_DIVN;
    else if (sel[0]) return MODE_AUTO8K;
    return MODE_DIRECT;
  endfunction

  // Preset ratios down to 8 kHz; zero marks an unsupported code
  function automatic logic [RATIO_W-1:0] auto_ratio(input logic [3:0] code);
    case (code)
      4'd1:    return RATIO_W'(193);
      4'd2:    return RATIO_W'(256);
      4'd3:    return RATIO_W'(810);
      4'd4:    return RATIO_W'(2430);
      4'd5:    return RATIO_W'(3240);
      4'd6:    return RATIO_W'(4860);
      4'd7:    return RATIO_W'(6480);
      4'd8:    return RATIO_W'(9720);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/ref_sync_edge.sv
module ref_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ref_in};
      prev_q <= level;
    end
  end

  assign edge_pulse = (level ^ prev_q) & (fall_sel ? ~level : level);
endmodule

// File: rtl/ratio_select.sv
module ratio_select
  import refdiv_pkg::*;
#(
  parameter int N_W = 16
) (
  input  mode_e              mode,
  input  logic [3:0]         code,
  input  logic [N_W-1:0]     n_value,
  output logic [RATIO_W-1:0] ratio,
  output logic               code_bad
);
  logic [RATIO_W-1:0] preset;
  logic [N_W-1:0]     n_plus;

  assign preset = auto_ratio(code);
  assign n_plus = n_value + N_W'(1);

  always_comb begin
    code_bad = 1'b0;
    unique case (mode)
      MODE_DIVN:   ratio = RATIO_W'(n_plus);
      MODE_AUTO8K: begin
        ratio    = preset;
        code_bad = (preset == '0);
      end
      default:     ratio = RATIO_W'(1);
    endcase
  end
endmodule

// File: rtl/div_counter.sv
module div_counter
  import refdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic               tick,
  input  logic [RATIO_W-1:0] ratio,
  output logic               evt
);
  logic [RATIO_W-1:0] cnt_q;
  logic               last;

  assign last = (cnt_q >= ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) begin
      cnt_q <= '0;
      evt   <= 1'b0;
    end else if (tick) begin
      cnt_q <= last ? '0 : cnt_q + RATIO_W'(1);
      evt   <= last;
    end else begin
      evt   <= 1'b0;
    end
  end
endmodule

// File: rtl/refclk_prediv.sv
module refclk_prediv
  import refdiv_pkg::*;
#(
  parameter int NUM_REFS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int N_MAX       = 12499,
  parameter int N_RESET     = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REFS-1:0]   ref_clk_in,
  input  logic [NUM_REFS*8-1:0] chan_cfg,
  input  logic                  edge_fall,
  input  logic                  n_hi_we,
  input  logic                  n_lo_we,
  input  logic [7:0]            n_wdata,
  output logic [NUM_REFS-1:0]   evt_out,
  output logic                  n_err,
  output logic [NUM_REFS-1:0]   code_err
);
  localparam int          N_W      = 16;
  localparam logic [7:0]  KEY_MASK = 8'hCF;

  logic [N_W-1:0]      n_q;
  logic                pol_q;
  logic                n_write;
  logic                pol_change;
  logic [NUM_REFS-1:0] divn_sel;

  assign n_write    = n_hi_we | n_lo_we;
  assign pol_change = (pol_q != edge_fall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q   <= N_W'(N_RESET);
      pol_q <= 1'b0;
    end else begin
      if (n_hi_we) n_q[15:8] <= n_wdata;
      if (n_lo_we) n_q[7:0]  <= n_wdata;
      pol_q <= edge_fall;
    end
  end

  assign n_err = (n_q == '0) || (n_q > N_W'(N_MAX));

  for (genvar ch = 0; ch < NUM_REFS; ch++) begin : g_ch
    logic [7:0]         key_now;
    logic [7:0]         key_q;
    mode_e              mode;
    logic [RATIO_W-1:0] ratio;
    logic               tick;
    logic               run;
    logic               clear;

    assign key_now = chan_cfg[ch*8 +: 8] & KEY_MASK;
    assign mode    = decode_mode(key_now[7:6]);

    always_ff @(posedge clk) begin
      if (!rst_n) key_q <= '0;
      else        key_q <= key_now;
    end

    ratio_select #(.N_W(N_W)) i_ratio (
      .mode     (mode),
      .code     (key_now[3:0]),
      .n_value  (n_q),
      .ratio    (ratio),
      .code_bad (code_err[ch])
    );

    ref_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_in     (ref_clk_in[ch]),
      .fall_sel   (edge_fall),
      .edge_pulse (tick)
    );

    assign divn_sel[ch] = (mode == MODE_DIVN);
    assign run          = ~code_err[ch] & ~(divn_sel[ch] & n_err);
    assign clear        = n_write | pol_change | (key_now != key_q);

    div_counter i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .run   (run),
      .tick  (tick),
      .ratio (ratio),
      .evt   (evt_out[ch])
    );
  end
endmodule

// File: rtl/refclk_prediv_chk.sv
module refclk_prediv_chk #(
  parameter int NUM_REFS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                n_hi_we,
  input logic                n_lo_we,
  input logic                n_err,
  input logic [NUM_REFS-1:0] divn_sel,
  input logic [NUM_REFS-1:0] code_err,
  input logic [NUM_REFS-1:0] evt_out
);
  // R3: the range flag only moves after a write strobe
  p_nerr_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(n_hi_we | n_lo_we) |-> $stable(n_err));

  for (genvar ch = 0; ch < NUM_REFS; ch++) begin : g_chk
    // R10: events are one cycle wide
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      evt_out[ch] |=> !evt_out[ch]);

    // R5: an unsupported preset code keeps the channel silent
    p_code_err_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(code_err[ch]) |-> !evt_out[ch]);

    // R3: an illegal N keeps programmable-divide channels silent
    p_bad_n_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(n_err && divn_sel[ch]) |-> !evt_out[ch]);

    // R9: a write to N restarts the period, so no event follows it
    p_no_evt_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(n_hi_we | n_lo_we) |-> !evt_out[ch]);

    // R6: programmable mode never reports a preset-code error
    p_divn_no_code_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
      divn_sel[ch] |-> !code_err[ch]);
  end
endmodule

bind refclk_prediv refclk_prediv_chk #(.NUM_REFS(NUM_REFS)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .n_hi_we  (n_hi_we),
  .n_lo_we  (n_lo_we),
  .n_err    (n_err),
  .divn_sel (divn_sel),
  .code_err (code_err),
  .evt_out  (evt_out)
);

// File: tb/test_refclk_prediv.sv
module test_refclk_prediv;
  localparam int CLK_PERIOD = 10;
  localparam int NR         = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] ref_clk_in = '0;
  logic [NR*8-1:0] chan_cfg = '0;
  logic          edge_fall = 1'b0;
  logic          n_hi_we = 1'b0;
  logic          n_lo_we = 1'b0;
  logic [7:0]    n_wdata = '0;
  logic [NR-1:0] evt_out;
  logic          n_err;
  logic [NR-1:0] code_err;

  int checks = 0;
  int fails  = 0;
  int seen [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_prediv #(.NUM_REFS(NR)) i_refclk_prediv (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .chan_cfg(chan_cfg),
    .edge_fall(edge_fall), .n_hi_we(n_hi_we), .n_lo_we(n_lo_we),
    .n_wdata(n_wdata), .evt_out(evt_out), .n_err(n_err), .code_err(code_err)
  );

  always @(negedge clk) begin
    for (int i = 0; i < NR; i++) if (rst_n && evt_out[i]) seen[i]++;
  end

  typedef struct packed {
    logic [7:0]  cfg;
    logic [15:0] n;
    logic        pol;
    logic [15:0] periods;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'd1,     1'b0, 16'd10,    16'd10}, // R1 direct, rising
    '{8'h00, 16'd1,     1'b1, 16'd7,     16'd7},  // R8 direct, falling
    '{8'h80, 16'd3,     1'b0, 16'd20,    16'd5},  // R2 divide by 4
    '{8'h80, 16'd1,     1'b0, 16'd7,     16'd3},  // R2 divide by 2 (N low bound)
    '{8'h41, 16'd1,     1'b0, 16'd400,   16'd2},  // R4 code 1 -> 193
    '{8'h42, 16'd1,     1'b0, 16'd600,   16'd2},  // R4 code 2 -> 256
    '{8'hC1, 16'd4,     1'b0, 16'd10,    16'd2},  // R6 both bits: divide by 5
    '{8'hB0, 16'd3,     1'b0, 16'd8,     16'd2},  // R7 tag bits set, divide by 4
    '{8'h4F, 16'd3,     1'b0, 16'd10,    16'd0},  // R5 unsupported code
    '{8'h80, 16'd12499, 1'b0, 16'd12500, 16'd1}   // R3 top of legal range
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_n(input logic [15:0] v);
    @(negedge clk); n_wdata = v[15:8]; n_hi_we = 1'b1;
    @(negedge clk); n_hi_we = 1'b0; n_wdata = v[7:0]; n_lo_we = 1'b1;
    @(negedge clk); n_lo_we = 1'b0;
  endtask

  task automatic pulse_refs(input logic [NR-1:0] mask, input int periods);
    for (int p = 0; p < periods; p++) begin
      @(negedge clk); ref_clk_in = ref_clk_in | mask;
      repeat (2) @(negedge clk);
      ref_clk_in = ref_clk_in & ~mask;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int b0, b1;
    for (int i = 0; i < NR; i++) seen[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 evt after reset", int'(evt_out), 0);
    check("R11 n_err after reset", int'(n_err), 0);
    check("R11 code_err after reset", int'(code_err), 0);
    b0 = seen[0];
    pulse_refs(2'b01, 3);
    check("R11 reset N is 1 (direct ok)", seen[0] - b0, 3);

    // table walk on channel 0
    for (int v = 0; v < NV; v++) begin
      chan_cfg[7:0] = VECS[v].cfg;
      edge_fall     = VECS[v].pol;
      write_n(VECS[v].n);
      settle();
      b0 = seen[0];
      pulse_refs(2'b01, int'(VECS[v].periods));
      check($sformatf("vector %0d (cfg %h)", v, VECS[v].cfg), seen[0] - b0, int'(VECS[v].exp));
    end
    edge_fall = 1'b0;

    // R5 / R6 error flag
    chan_cfg[7:0] = 8'h4F; #1;
    check("R5 code_err on bad code", int'(code_err[0]), 1);
    chan_cfg[7:0] = 8'h41; #1;
    check("R5 code_err low on good code", int'(code_err[0]), 0);
    chan_cfg[7:0] = 8'hCF; #1;
    check("R6 code_err low when both bits set", int'(code_err[0]), 0);

    // R3 illegal N values
    chan_cfg = {8'h00, 8'h80};
    write_n(16'd0); settle();
    check("R3 n_err for N=0", int'(n_err), 1);
    b0 = seen[0]; b1 = seen[1];
    pulse_refs(2'b11, 10);
    check("R3 no events with N=0", seen[0] - b0, 0);
    check("R1 direct neighbour unaffected", seen[1] - b1, 10);
    write_n(16'd12500); settle();
    check("R3 n_err for N=12500", int'(n_err), 1);
    write_n(16'd2); settle();
    check("R3 n_err cleared by legal N", int'(n_err), 0);
    b0 = seen[0];
    pulse_refs(2'b01, 6);
    check("R3 legal N restores divide by 3", seen[0] - b0, 2);

    // R9 restarts
    write_n(16'd3); settle();
    b0 = seen[0];
    pulse_refs(2'b01, 3);
    write_n(16'd3); settle();
    pulse_refs(2'b01, 1);
    check("R9 N rewrite restarts period", seen[0] - b0, 0);
    pulse_refs(2'b01, 3);
    check("R9 full period after rewrite", seen[0] - b0, 1);
    b0 = seen[0];
    pulse_refs(2'b01, 3);
    chan_cfg[7:0] = 8'h00; settle();
    chan_cfg[7:0] = 8'h80; settle();
    pulse_refs(2'b01, 1);
    check("R9 mode change restarts period", seen[0] - b0, 0);
    b0 = seen[0];
    pulse_refs(2'b01, 2);
    edge_fall = 1'b1; settle();
    edge_fall = 1'b0; settle();
    pulse_refs(2'b01, 2);
    check("R9 polarity change restarts period", seen[0] - b0, 0);
    b0 = seen[0];
    pulse_refs(2'b01, 3);
    chan_cfg[7:0] = 8'hB0; settle();
    pulse_refs(2'b01, 1);
    check("R7 tag change keeps period", seen[0] - b0, 1);

    // R10 latency and width, rising
    chan_cfg = '0; settle();
    @(negedge clk); ref_clk_in[0] = 1'b1;
    @(negedge clk); check("R10 latency +1", int'(evt_out[0]), 0);
    @(negedge clk); check("R10 latency +2", int'(evt_out[0]), 0);
    @(negedge clk); check("R10 event at +3", int'(evt_out[0]), 1);
    @(negedge clk); check("R10 one cycle wide", int'(evt_out[0]), 0);
    b0 = seen[0];
    ref_clk_in[0] = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 falling ignored when rising selected", seen[0] - b0, 0);

    // R8 falling selected
    edge_fall = 1'b1; settle();
    b0 = seen[0];
    ref_clk_in[0] = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 rising ignored when falling selected", seen[0] - b0, 0);
    ref_clk_in[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    @(negedge clk); check("R8 falling event at +3", int'(evt_out[0]), 1);
    @(negedge clk); check("R10 falling event one cycle wide", int'(evt_out[0]), 0);
    edge_fall = 1'b0; settle();

    // both channels in different modes
    chan_cfg = {8'h00, 8'h80};
    write_n(16'd3); settle();
    b0 = seen[0]; b1 = seen[1];
    pulse_refs(2'b11, 8);
    check("R2 channel 0 divide by 4", seen[0] - b0, 2);
    check("R1 channel 1 direct", seen[1] - b1, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule